// File: doc/BRIEF.md
# I2C serial memory slave

This block is an I2C-bus slave that sits in front of an internal byte-wide memory of 2048 locations. A bus master reaches it by sending an address byte that carries a fixed device-type code, three block-select bits and a direction bit. Write transfers set an internal 11-bit address counter and store bytes. Read transfers return bytes from wherever that counter points. The counter persists between transfers, which allows three ways to read: continue from the counter (current-address read), set the counter with a write that carries only a word address and then turn round with a repeated START (random read), or keep acknowledging to stream bytes (sequential read).

SCL and SDA enter through synchronizers that are clocked by the system clock. The slave never drives SDA high. It pulls the line low through a registered output-enable and reads the resolved line back on a separate input. START, repeated START and STOP are recognised from the synchronized lines, and any of them ends the transfer in progress. Writes advance the counter only inside a 16-byte page. Reads advance all 11 bits and wrap from the top of the array to zero.

Top module: `i2cm_slave`

## Requirements
- R1: After reset, and whenever no transfer is addressing the slave, SDA is not driven (sda_oe = 0).
- R2: The slave acknowledges an address byte only when its upper four bits (bits 7..4) are 1010. Any other value gets no acknowledge, and the slave ignores the bus until the next START.
- R3: On a write-direction address byte (bit 0 = 0), bits 3..1 become counter bits 10..8. The following word-address byte becomes counter bits 7..0. The slave acknowledges both bytes.
- R4: Each complete data byte in a write is stored at the counter location and acknowledged.
- R5: After each stored byte, counter bits 3..0 increment and wrap within their page without changing bits 10..4.
- R6: On a read-direction address byte (bit 0 = 1), the slave acknowledges and then transmits the byte at the counter, most significant bit first.
- R7: After each transmitted byte, the full 11-bit counter increments, and 2047 wraps to 0.
- R8: When the master acknowledges, the next byte follows. When it does not acknowledge, SDA is released and stays released until a START or STOP.
- R9: A repeated START after a write of only the word address, followed by a read-direction address byte, starts a read at that word address.
- R10: A read-direction transfer starts from the counter value left by the previous transfer, whatever its block-select bits.
- R11: A START or STOP in the middle of a byte abandons the transfer. A partial data byte is not stored, and the next START is served normally.
- R12: The slave changes its SDA drive only after it sees SCL fall, or on START or STOP. It never changes the drive while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Resolved serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |

## Verification
The hardest conditions to reach are the counter edges. These are the write that crosses a 16-byte page boundary without disturbing the next page, and the sequential read that passes from location 2047 to location 0. Both need chosen bytes already stored on each side of the boundary. The stimulus therefore pre-writes guard and boundary locations with directed transfers, then reads across them with random reads and current-address reads. Transfers abandoned mid-byte by START or STOP are mixed in among random-address write and read-back sequences.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring bus until START
    ST_DEV,    // shifting in address byte
    ST_WORD,   // shifting in word address
    ST_WDATA,  // shifting in write data
    ST_ACK,    // slave holding acknowledge low
    ST_RDATA,  // slave transmitting a byte
    ST_RACK,   // master acknowledge slot
    ST_WAIT    // released, waiting for START/STOP
  } i2cm_state_t;
endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl       = scl_sh[STAGES-1];
  assign sda       = sda_sh[STAGES-1];
  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_det = scl & scl_p & sda_p & ~sda;
  assign stop_det  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave #(
  parameter int         AW      = 11,
  parameter int         PAGE_W  = 4,
  parameter logic [3:0] DEV_ID  = 4'b1010,
  parameter int         SYNC_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  import i2cm_pkg::*;
  localparam int DW    = 8;
  localparam int BLK_W = AW - DW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic scl, sda, scl_rise, scl_fall, start_det, stop_det;
  i2cm_state_t state, nxt;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg, txreg, rdata, wdata_r;
  logic [AW-1:0] addr, waddr_r;
  logic          we_r, mack;

  i2cm_bus_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl(scl), .sda(sda), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cm_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(we_r), .waddr(waddr_r), .wdata(wdata_r),
    .raddr(addr), .rdata(rdata)
  );

  wire receiving = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
  wire byte_in   = receiving && scl_fall && (bitcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      addr    <= '0;
      waddr_r <= '0;
      wdata_r <= '0;
      we_r    <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      we_r <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (receiving && scl_rise && bitcnt < 4'd8) begin
          shreg  <= {shreg[DW-2:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (byte_in) begin
          bitcnt <= '0;
          unique case (state)
            ST_DEV: begin
              if (shreg[7:4] == DEV_ID) begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
                if (shreg[0]) nxt <= ST_RDATA;
                else begin
                  nxt <= ST_WORD;
                  addr[AW-1 -: BLK_W] <= shreg[BLK_W:1];
                end
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WORD: begin
              addr[DW-1:0] <= shreg;
              state  <= ST_ACK;
              nxt    <= ST_WDATA;
              sda_oe <= 1'b1;
            end
            default: begin
              we_r    <= 1'b1;
              waddr_r <= addr;
              wdata_r <= shreg;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
              state  <= ST_ACK;
              nxt    <= ST_WDATA;
              sda_oe <= 1'b1;
            end
          endcase
        end
        if (state == ST_ACK && scl_fall) begin
          bitcnt <= '0;
          state  <= nxt;
          if (nxt == ST_RDATA) begin
            txreg  <= rdata;
            sda_oe <= ~rdata[DW-1];
          end else begin
            sda_oe <= 1'b0;
          end
        end
        if (state == ST_RDATA && scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
            addr   <= addr + ONE;
          end else begin
            txreg  <= {txreg[DW-2:0], 1'b0};
            sda_oe <= ~txreg[DW-2];
            bitcnt <= bitcnt + 4'd1;
          end
        end
        if (state == ST_RACK) begin
          if (scl_rise) mack <= ~sda;
          if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state  <= ST_RDATA;
              txreg  <= rdata;
              sda_oe <= ~rdata[DW-1];
            end else begin
              state <= ST_WAIT;
            end
          end
        end
      end
    end
  end

  // R12: drive changes only as a response to SCL falling, START or STOP
  a_r12_oe_after_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));
  // R5: a stored byte advances only the in-page bits
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (rst)
    we_r |-> (addr[AW-1:PAGE_W] == waddr_r[AW-1:PAGE_W]) &&
             (addr[PAGE_W-1:0] == waddr_r[PAGE_W-1:0] + 1'b1));
  // R7: every transmitted byte advances the whole counter, wrapping at the top
  a_r7_read_inc: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && scl_fall && bitcnt == 4'd7 && !start_det && !stop_det)
    |=> addr == $past(addr) + ONE);
  // R8: after a missing master acknowledge the line stays released
  a_r8_nack_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !sda_oe);
  // R6 / R3: acknowledge slot holds SDA low
  a_r6_ack_drive: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK) |-> sda_oe);
  // R1: no drive while idle
  a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: tb/tb_i2cm_slave.sv
module tb_i2cm_slave;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = ~(sda_oe | ~m_sda);

  always #10 clk = ~clk;

  i2cm_slave dut (.clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe));

  int tests = 0;
  int fails = 0;
  int r12_viol = 0;
  bit done = 1'b0;
  logic [7:0]  model [0:2047];
  bit          valid [0:2047];
  logic [10:0] maddr;

  function automatic logic [10:0] pg_inc(input logic [10:0] a);
    return {a[10:4], a[3:0] + 4'd1};
  endfunction
  function automatic logic [10:0] rd_inc(input logic [10:0] a);
    return a + 11'd1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R12 monitor: drive must hold still while SCL stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst && m_scl && prev_scl && sda_oe !== prev_oe) r12_viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic ack);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); m_scl = 1'b1; tick(Q); b = {b[6:0], sda_bus}; tick(Q); m_scl = 1'b0;
    end
    tick(Q);
    m_sda = ~ack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic read_bytes(input string tag, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      if (valid[maddr]) chk(tag, d, model[maddr]);
      maddr = rd_inc(maddr);
    end
    tick(2);
    chk("R8 released after NACK", sda_oe, 0);
  endtask

  task automatic do_write(input logic [10:0] a, input int n);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); chk("R2 device ack", ack, 1);
    maddr[10:8] = a[10:8];
    send_byte(a[7:0], ack); chk("R3 word ack", ack, 1);
    maddr[7:0] = a[7:0];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk("R4 data ack", ack, 1);
      model[maddr] = d; valid[maddr] = 1'b1;
      maddr = pg_inc(maddr);
    end
    i2c_stop();
  endtask

  task automatic do_read_cur(input string tag, input int n);
    logic ack;
    i2c_start();
    send_byte({4'b1010, 3'($urandom), 1'b1}, ack); chk("R10 read ack", ack, 1);
    read_bytes(tag, n);
    i2c_stop();
  endtask

  task automatic do_read_rand(input string tag, input logic [10:0] a, input int n);
    logic ack;
    i2c_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); chk("R3 device ack", ack, 1);
    send_byte(a[7:0], ack); chk("R3 word ack", ack, 1);
    maddr = a;
    i2c_start();
    send_byte({4'b1010, 3'($urandom), 1'b1}, ack); chk("R9 repeated START ack", ack, 1);
    read_bytes(tag, n);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 2048; i++) valid[i] = 1'b0;
    maddr = '0;
    tick(5); rst = 1'b0; tick(5);
    chk("R1 reset release", sda_oe, 0);

    // R2: foreign device type gets no acknowledge and no drive
    i2c_start();
    send_byte(8'b1011_0000, ack); chk("R2 foreign no ack", ack, 0);
    send_byte(8'h00, ack); chk("R2 ignored byte", ack, 0);
    i2c_stop();
    chk("R1 idle release", sda_oe, 0);

    // R5: guard byte in next page, then a write that wraps inside its page
    do_write(11'h110, 1);
    do_write(11'h10E, 3);
    do_read_rand("R5 page wrap readback", 11'h10E, 2);
    do_read_rand("R5 wrapped byte at page start", 11'h100, 1);
    do_read_rand("R5 guard byte untouched", 11'h110, 1);

    // R7: sequential read across the top of the array
    do_write(11'h7FF, 1);
    do_write(11'h000, 3);
    do_read_rand("R7 read wrap", 11'h7FF, 3);
    do_read_cur("R10 current address", 1);

    // R8: after NACK the slave stays off the bus while clocks continue
    do_read_rand("R8 data", 11'h000, 1);
    i2c_start();
    send_byte(8'hA1, ack); chk("R6 read ack", ack, 1);
    recv_byte(d, 1'b0);
    if (valid[maddr]) chk("R6 data", d, model[maddr]);
    maddr = rd_inc(maddr);
    recv_byte(d, 1'b0);
    chk("R8 line released after NACK", d, 8'hFF);
    i2c_stop();

    // R11: STOP in the middle of a data byte
    do_write(11'h123, 1);
    i2c_start();
    send_byte(8'b1010_0010, ack); chk("R11 device ack", ack, 1);
    send_byte(8'h23, ack); chk("R11 word ack", ack, 1);
    maddr = 11'h123;
    for (int i = 0; i < 4; i++) send_bit(~model[11'h123][7-i]);
    i2c_stop();
    do_read_cur("R11 partial byte not stored", 1);

    // R11: START in the middle of an address byte, then a normal read
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_read_rand("R11 after aborted address", 11'h7FF, 2);

    // Random mix
    for (int it = 0; it < 22; it++) begin
      logic [10:0] a;
      int n;
      a = 11'($urandom);
      n = 1 + int'($urandom % 4);
      do_write(a, n);
      do_read_rand("R4 random readback", a, n);
      if (it % 3 == 0) do_read_cur("R10 random current read", 1);
    end

    chk("R12 drive stable while SCL high", r12_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule